// File: doc/BRIEF.md
# Page-Load Buffer Write Controller

This block is the host-facing write front end of a byte-wide non-volatile memory model. The host sends single-byte writes on a synchronous strobe. The first accepted byte opens a load cycle and latches the page number from the upper address bits. Further bytes for the same page may follow in any order, and each one keeps the cycle open. When a configurable number of clock cycles passes with no accepted byte, the block closes the cycle and raises a one-cycle commit request that carries the page number.

While the internal programming period runs, the block reports busy and ignores writes. A backing array reads the 128-byte page image through a byte index port. Any byte that was not written in the current load cycle reads back as FFh, so a committed page never carries stale data from an earlier cycle.

A byte aimed at a page other than the latched one is dropped and sets a sticky error flag. The window timer does not restart for it.

Top module: `page_load_ctrl`

## Requirements
- R1: The address splits as addr[15:7] = page number and addr[6:0] = byte index within the page. rd_data returns the page-image byte selected by rd_idx.
- R2: Bytes of one load cycle are accepted at any index and in any order. Each index holds the last value written to it.
- R3: A strobe counts as a write only when wr_stb=1, cs_en=1, wr_en=1 and rd_en=0. With cs_en=0, wr_en=0 or rd_en=1 the strobe has no effect.
- R4: Suppose the last accepted byte of a cycle is taken at clock edge k. Then commit_req is 1 for exactly the one cycle that follows edge k+LOAD_WIN, and it is 0 at every earlier cycle of the load.
- R5: commit_page equals the page latched by the first byte of the cycle, and it holds steady for as long as busy is high.
- R6: rd_data reads FFh for every index that was not written in the current load cycle.
- R7: busy rises together with commit_req and stays high for exactly PROG_CYC cycles.
- R8: An accepted-looking strobe while busy is ignored. Buffer contents do not change and no new load cycle starts.
- R9: A byte whose page differs from the latched page is ignored. It sets page_err, which stays set until reset, and it does not restart the load window.
- R10: After reset, busy=0, commit_req=0, page_err=0 and every index reads FFh.
- R11: The first byte of a new load cycle clears the loaded set. Bytes written only in an earlier cycle read FFh again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_stb | input | 1 | Write strobe, one cycle per byte |
| cs_en | input | 1 | Chip select, active high |
| wr_en | input | 1 | Write enable, active high |
| rd_en | input | 1 | Output enable, active high; blocks writes |
| addr | input | 16 | Byte address: page in [15:7], index in [6:0] |
| wdata | input | 8 | Write data |
| rd_idx | input | 7 | Read-out byte index for the backing array |
| rd_data | output | 8 | Page-image byte at rd_idx, FFh if not loaded |
| busy | output | 1 | Programming period in progress |
| commit_req | output | 1 | One-cycle page commit pulse |
| commit_page | output | 9 | Page number being committed |
| page_err | output | 1 | Sticky off-page write flag |

## Verification
The assertions take for granted that the strobe is sampled once per clock as a single-cycle pulse, and that the backing array reads only while the page image is stable. Under that assumption, mask bits can only grow inside a cycle and the commit page cannot move while busy.

Random loads keep the gap between consecutive same-page bytes well below LOAD_WIN, so a cycle closes only where the bench intends. Inhibited strobes are mixed into those gaps and count as idle time. Off-page and busy-time writes are driven only in directed cases, with the expected window timing tracked alongside.

// File: rtl/pgload_pkg.sv
package pgload_pkg;

    localparam int BYTE_W = 8;
    localparam logic [BYTE_W-1:0] ERASED_BYTE = 8'hFF;

    typedef enum logic [1:0] {
        PL_IDLE,
        PL_LOAD,
        PL_PROG
    } pl_state_e;

    typedef struct packed {
        logic clr;   // first byte of a new load cycle
        logic wr;    // store byte and mark it loaded
    } buf_ctl_t;

    function automatic logic [BYTE_W-1:0] fill_byte(input logic loaded,
                                                    input logic [BYTE_W-1:0] d);
        return loaded ? d : ERASED_BYTE;
    endfunction

    function automatic logic write_ok(input logic stb, input logic cs,
                                      input logic we, input logic oe);
        return stb & cs & we & ~oe;
    endfunction

endpackage

// File: rtl/pl_buf.sv
module pl_buf
    import pgload_pkg::*;
#(
    parameter int PAGE_BYTES = 128,
    parameter int IDX_W      = $clog2(PAGE_BYTES)
) (
    input  logic              clk,
    input  logic              rst,
    input  buf_ctl_t          ctl,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [BYTE_W-1:0] rd_data
);

    logic [PAGE_BYTES-1:0] mask_q;
    logic [BYTE_W-1:0]     data_q [PAGE_BYTES];

    for (genvar i = 0; i < PAGE_BYTES; i++) begin : g_byte
        logic hit;
        assign hit = ctl.wr && (wr_idx == IDX_W'(i));

        always_ff @(posedge clk) begin
            if (rst) begin
                mask_q[i] <= 1'b0;
                data_q[i] <= '0;
            end else begin
                mask_q[i] <= (ctl.clr ? 1'b0 : mask_q[i]) | hit;
                if (hit) data_q[i] <= wr_data;
            end
        end
    end

    assign rd_data = fill_byte(mask_q[rd_idx], data_q[rd_idx]);

    AST_MASK_GROWS: assert property (@(posedge clk) disable iff (rst)
        !ctl.clr |=> ((mask_q & $past(mask_q)) == $past(mask_q)));      // R6
    AST_MASK_FRESH: assert property (@(posedge clk) disable iff (rst)
        (ctl.clr && ctl.wr) |=> ($countones(mask_q) == 1));             // R11

endmodule

// File: rtl/pl_seq.sv
module pl_seq
    import pgload_pkg::*;
#(
    parameter int PAGE_W   = 9,
    parameter int LOAD_WIN = 20,
    parameter int PROG_CYC = 30
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              acc,
    input  logic [PAGE_W-1:0] page_in,
    output buf_ctl_t          ctl,
    output logic              busy,
    output logic              commit_req,
    output logic [PAGE_W-1:0] commit_page,
    output logic              page_err
);

    localparam int TMAX  = (LOAD_WIN > PROG_CYC) ? LOAD_WIN : PROG_CYC;
    localparam int CNT_W = $clog2(TMAX + 1);

    pl_state_e         state_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [PAGE_W-1:0] page_q;
    logic              req_q;
    logic              err_q;
    logic              same_page;

    assign same_page = (page_in == page_q);

    always_comb begin
        ctl.clr = acc && (state_q == PL_IDLE);
        ctl.wr  = acc && ((state_q == PL_IDLE) ||
                          ((state_q == PL_LOAD) && same_page));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= PL_IDLE;
            cnt_q   <= '0;
            page_q  <= '0;
            req_q   <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            req_q <= 1'b0;
            unique case (state_q)
                PL_IDLE: begin
                    if (acc) begin
                        page_q  <= page_in;
                        cnt_q   <= '0;
                        state_q <= PL_LOAD;
                    end
                end
                PL_LOAD: begin
                    if (acc && same_page) begin
                        cnt_q <= '0;
                    end else begin
                        if (acc) err_q <= 1'b1;
                        if (cnt_q == CNT_W'(LOAD_WIN - 1)) begin
                            cnt_q   <= '0;
                            req_q   <= 1'b1;
                            state_q <= PL_PROG;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                end
                PL_PROG: begin
                    if (cnt_q == CNT_W'(PROG_CYC - 1)) begin
                        cnt_q   <= '0;
                        state_q <= PL_IDLE;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                default: state_q <= PL_IDLE;
            endcase
        end
    end

    assign busy        = (state_q == PL_PROG);
    assign commit_req  = req_q;
    assign commit_page = page_q;
    assign page_err    = err_q;

    AST_COMMIT_BUSY: assert property (@(posedge clk) disable iff (rst)
        commit_req |-> busy);                                            // R7
    AST_COMMIT_PULSE: assert property (@(posedge clk) disable iff (rst)
        commit_req |=> !commit_req);                                     // R4
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
        page_err |=> page_err);                                          // R9
    AST_PAGE_HELD: assert property (@(posedge clk) disable iff (rst)
        (busy && !commit_req) |-> $stable(commit_page));                 // R5
    AST_NO_WRITE_BUSY: assert property (@(posedge clk) disable iff (rst)
        busy |-> !ctl.wr);                                               // R8
    AST_WIN_BOUND: assert property (@(posedge clk) disable iff (rst)
        (state_q == PL_LOAD) |-> (cnt_q < CNT_W'(LOAD_WIN)));            // R4

endmodule

// File: rtl/page_load_ctrl.sv
module page_load_ctrl
    import pgload_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int PAGE_BYTES = 128,
    parameter int LOAD_WIN   = 20,
    parameter int PROG_CYC   = 30,
    localparam int IDX_W     = $clog2(PAGE_BYTES),
    localparam int PAGE_W    = ADDR_W - IDX_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_stb,
    input  logic              cs_en,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BYTE_W-1:0] wdata,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [BYTE_W-1:0] rd_data,
    output logic              busy,
    output logic              commit_req,
    output logic [PAGE_W-1:0] commit_page,
    output logic              page_err
);

    logic     acc;
    buf_ctl_t ctl;

    assign acc = write_ok(wr_stb, cs_en, wr_en, rd_en);

    pl_seq #(
        .PAGE_W  (PAGE_W),
        .LOAD_WIN(LOAD_WIN),
        .PROG_CYC(PROG_CYC)
    ) u_seq (
        .clk        (clk),
        .rst        (rst),
        .acc        (acc),
        .page_in    (addr[ADDR_W-1:IDX_W]),
        .ctl        (ctl),
        .busy       (busy),
        .commit_req (commit_req),
        .commit_page(commit_page),
        .page_err   (page_err)
    );

    pl_buf #(
        .PAGE_BYTES(PAGE_BYTES),
        .IDX_W     (IDX_W)
    ) u_buf (
        .clk    (clk),
        .rst    (rst),
        .ctl    (ctl),
        .wr_idx (addr[IDX_W-1:0]),
        .wr_data(wdata),
        .rd_idx (rd_idx),
        .rd_data(rd_data)
    );

    AST_INHIBIT: assert property (@(posedge clk) disable iff (rst)
        !acc |-> !ctl.wr);                                               // R3

endmodule

// File: tb/tb_page_load_ctrl.sv
module tb_page_load_ctrl;

    localparam int LW = 20;
    localparam int PC = 30;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_stb = 1'b0, cs_en = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
    logic [15:0] addr = '0;
    logic [7:0]  wdata = '0;
    logic [6:0]  rd_idx = '0;
    logic [7:0]  rd_data;
    logic        busy, commit_req, page_err;
    logic [8:0]  commit_page;

    page_load_ctrl #(.LOAD_WIN(LW), .PROG_CYC(PC)) dut (
        .clk(clk), .rst(rst), .wr_stb(wr_stb), .cs_en(cs_en), .wr_en(wr_en),
        .rd_en(rd_en), .addr(addr), .wdata(wdata), .rd_idx(rd_idx),
        .rd_data(rd_data), .busy(busy), .commit_req(commit_req),
        .commit_page(commit_page), .page_err(page_err)
    );

    always #5 clk = ~clk;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    logic [7:0] m_data [128];
    bit         m_mask [128];
    bit         in_load = 0;
    logic [8:0] cur_page = '0;
    int         since = 0;
    bit         exp_err = 0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_byte(input int i);
        return m_mask[i] ? m_data[i] : 8'hFF;
    endfunction

    task automatic idle_cyc();
        @(negedge clk);
        if (in_load) since++;
    endtask

    // Drive one strobe at a negedge; the model follows R3, R9, R11.
    task automatic put(input logic [15:0] a, input logic [7:0] d,
                       input logic cs, input logic we, input logic oe);
        bit ok;
        addr = a; wdata = d; cs_en = cs; wr_en = we; rd_en = oe; wr_stb = 1'b1;
        @(negedge clk);
        wr_stb = 1'b0; cs_en = 1'b0; wr_en = 1'b0; rd_en = 1'b0;
        ok = cs && we && !oe;
        if (ok && !in_load) begin
            in_load  = 1;
            cur_page = a[15:7];
            for (int i = 0; i < 128; i++) m_mask[i] = 0;
            m_data[a[6:0]] = d; m_mask[a[6:0]] = 1;
            since = 0;
        end else if (ok && a[15:7] == cur_page) begin
            m_data[a[6:0]] = d; m_mask[a[6:0]] = 1;
            since = 0;
        end else begin
            if (ok) exp_err = 1;
            if (in_load) since++;
        end
    endtask

    task automatic sweep(input string req);
        for (int i = 0; i < 128; i++) begin
            rd_idx = 7'(i);
            #1;
            chk(req, rd_data, exp_byte(i));
        end
        @(negedge clk);
    endtask

    // Wait out the window, check commit timing, busy length and optional busy poke.
    task automatic finish_page(input bit poke);
        int n;
        while (since < LW) begin
            @(negedge clk);
            since++;
            if (since < LW) chk("R4 no early commit", commit_req, 0);
        end
        chk("R4 commit pulse", commit_req, 1);
        chk("R7 busy with commit", busy, 1);
        chk("R5 commit page", commit_page, cur_page);
        in_load = 0;
        n = 1;
        for (int g = 0; g < 3 * PC; g++) begin
            if (poke && n == 2) begin
                addr = {cur_page, 7'd0}; wdata = ~exp_byte(0);
                cs_en = 1; wr_en = 1; rd_en = 0; wr_stb = 1;
            end
            @(negedge clk);
            wr_stb = 0; cs_en = 0; wr_en = 0;
            if (commit_req) chk("R4 single pulse", commit_req, 0);
            if (busy) begin
                if (commit_page !== cur_page) chk("R5 page held", commit_page, cur_page);
                n++;
            end else break;
        end
        chk("R7 busy length", n, PC);
        sweep(poke ? "R8 contents after busy write" : "R6 page image");
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : main
        int seed;
        int nb, gap, sel;
        logic [8:0] pg;
        seed = $urandom(32'h5EED);
        for (int i = 0; i < 128; i++) begin m_data[i] = 0; m_mask[i] = 0; end

        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        chk("R10 busy", busy, 0);
        chk("R10 commit", commit_req, 0);
        chk("R10 err", page_err, 0);
        sweep("R10 erased image");

        // R3: inhibited strobes start nothing
        put(16'h1234, 8'h11, 0, 1, 0);
        put(16'h1234, 8'h22, 1, 0, 0);
        put(16'h1234, 8'h33, 1, 1, 1);
        for (int j = 0; j < LW + 3; j++) begin
            @(negedge clk);
            if (busy || commit_req) chk("R3 inhibit starts nothing", {busy, commit_req}, 0);
        end
        chk("R3 still idle", busy, 0);
        sweep("R3 image untouched");

        // R2 full page in reverse order, R1 index mapping
        for (int i = 127; i >= 0; i--) put({9'h1A5, 7'(i)}, 8'(i) ^ 8'h3C, 1, 1, 0);
        finish_page(0);

        // R11 next cycle on same page loads only three bytes
        put({9'h1A5, 7'd4}, 8'hA1, 1, 1, 0);
        idle_cyc();
        put({9'h1A5, 7'd90}, 8'hB2, 1, 1, 0);
        put({9'h1A5, 7'd4}, 8'hC3, 1, 1, 0);
        finish_page(0);
        rd_idx = 7'd5; #1; chk("R11 old byte erased", rd_data, 8'hFF);
        rd_idx = 7'd4; #1; chk("R2 last write wins", rd_data, 8'hC3);
        @(negedge clk);

        // Random loads, gaps hold inhibited strobes (R3) and stay inside the window
        for (int r = 0; r < 8; r++) begin
            pg = 9'($urandom % 512);
            nb = 1 + int'($urandom % 24);
            for (int b = 0; b < nb; b++) begin
                put({pg, 7'($urandom % 128)}, 8'($urandom), 1, 1, 0);
                gap = int'($urandom % (LW - 4));
                for (int g = 0; g < gap; g++) begin
                    sel = int'($urandom % 4);
                    if (sel == 0)      put({pg, 7'($urandom)}, 8'($urandom), 0, 1, 0);
                    else if (sel == 1) put({pg, 7'($urandom)}, 8'($urandom), 1, 1, 1);
                    else               idle_cyc();
                end
            end
            finish_page(0);
        end
        chk("R9 no error on clean loads", page_err, 0);

        // R9 off-page byte ignored, window not restarted; R8 write while busy
        put({9'h0F0, 7'd5}, 8'h5A, 1, 1, 0);
        idle_cyc(); idle_cyc();
        put({9'h0F1, 7'd5}, 8'hEE, 1, 1, 0);
        chk("R9 error set", page_err, 1);
        finish_page(1);
        for (int j = 0; j < LW + 3; j++) begin
            @(negedge clk);
            if (busy || commit_req) chk("R8 no cycle from busy write", {busy, commit_req}, 0);
        end
        chk("R9 error sticky", page_err, exp_err);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule